// File: doc/BRIEF.md
# Sample-and-Hold Refresh Sequencer

This controller keeps a bank of sample-and-hold channels topped up from a small code memory that is shared with one DAC. It visits the channels in ascending order and wraps around. Each visit is one step of four sub-cycles. At the start of the step the stored code is latched onto the DAC bus, and in the last sub-cycle the channel is strobed to take a sample. Sub-cycles are paced by an internal divider on the system clock or by rising edges of an external pacing clock. With the external clock, a step therefore lasts four external periods. If that clock stops, the sequencer stops with it.

A serial receiver writes words into the memory while its select flag is active. Refreshing pauses while select is active. The step in progress when select arrives is always finished first. In burst fashion the new codes reach their channels only when their turn comes round. An immediate write instead gets one priority step on its own channel once select drops. In both cases the rotation then continues at the channel that was interrupted. An asynchronous reset starts an uninterruptible pass that writes a default code into every entry in address order, paced by the internal divider. A busy flag lets the receiver hold off its writes during that pass.

Top module: `sh_refresh_seq`

## Requirements
- R1: With select inactive and no pending immediate write, successive steps refresh channels 0, 1, …, NCH-1 and then wrap to 0. The code on `dac_code` at each strobe is the last value written to that channel.
- R2: With internal pacing, a sub-cycle lasts TICK_DIV clock cycles, so successive rising edges of `sample` are exactly 4*TICK_DIV cycles apart.
- R3: With external pacing, one step is consumed for every four rising edges of `ext_clk`. The internal divider is held idle, and with no `ext_clk` edges no strobe occurs.
- R4: External pacing is selected when `ext_pin` is 1 or when the most recent accepted write had `wr_ext` = 1. Otherwise internal pacing is used.
- R5: While `sel_act` is 1, the step under way completes and no further step starts. The sequencer stays suspended as long as select is held.
- R6: After a suspension without an immediate write, the first step refreshes the interrupted channel and the rotation continues from there. The NCH steps that follow therefore refresh every channel with its newly written code.
- R7: A write with `wr_imm` = 1 or `imm_pin` = 1 marks an immediate update. After `sel_act` falls, a step for the most recently immediate-written channel strobes within 8*TICK_DIV cycles (at most two steps). The next step is the interrupted channel, followed by its successor.
- R8: After reset, `busy` stays high for exactly NCH*4*TICK_DIV clock cycles. During that pass the strobes go to channels 0 to NCH-1 in order, each with DEFAULT_CODE (0x4F2C). The pass uses internal pacing whatever `ext_pin` says and ignores `sel_act`. Afterwards every channel holds DEFAULT_CODE and the rotation starts at channel 0.
- R9: Writes presented while `busy` is 1 are discarded and leave the memory unchanged.
- R10: `sample` is high only in the fourth sub-cycle of a step. `dac_code` and `chan` do not change between the start of a step and its strobe.
- R11: While reset is asserted, `busy` = 1, `sample` = 0, `chan` = 0 and `dac_code` = DEFAULT_CODE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low; starts the default pass |
| wr_en | input | 1 | Write strobe from the serial receiver |
| wr_addr | input | AW | Channel written |
| wr_data | input | DW | Code written |
| wr_imm | input | 1 | Immediate-update bit of the written word |
| wr_ext | input | 1 | External-pacing bit of the written word |
| sel_act | input | 1 | Serial select active; suspends refresh |
| imm_pin | input | 1 | Immediate-update mode forced by pin |
| ext_pin | input | 1 | External pacing forced by pin |
| ext_clk | input | 1 | External pacing clock, synchronous to clk |
| dac_code | output | DW | Code presented to the DAC for the current step |
| chan | output | AW | Channel of the current step |
| sample | output | 1 | Sample strobe for channel `chan` |
| busy | output | 1 | Default pass in progress; writes are refused |

## Verification
A wrong rotation pointer shows up at the first strobe after a suspension. That strobe names the wrong channel, which exposes a lost interrupted address within one or two steps. A stale or wrongly bypassed memory word shows up as a wrong `dac_code` at the strobe of that channel, at the latest one full rotation after the write. Faulty pacing or a faulty divider changes the spacing between strobes on the very next step. A lost or sticky immediate flag moves or repeats the priority strobe right after select drops, and a wrong pass length is visible as the exact cycle on which `busy` falls.

// File: rtl/sh_refresh_seq.sv
module sh_refresh_seq #(
  parameter int NCH = 32,
  parameter int DW = 16,
  parameter int TICK_DIV = 1250,
  parameter logic [DW-1:0] DEFAULT_CODE = 16'h4F2C,
  localparam int AW = $clog2(NCH),
  localparam int TW = $clog2(TICK_DIV + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          wr_imm,
  input  logic          wr_ext,
  input  logic          sel_act,
  input  logic          imm_pin,
  input  logic          ext_pin,
  input  logic          ext_clk,
  output logic [DW-1:0] dac_code,
  output logic [AW-1:0] chan,
  output logic          sample,
  output logic          busy
);

  typedef enum logic [1:0] {S_RST, S_RUN, S_HOLD, S_IMM} st_t;

  logic [DW-1:0] mem [NCH];
  st_t           st, st_n;
  logic [1:0]    ph;
  logic [AW-1:0] ch, ch_n, ptr, ptr_n, imm_ch;
  logic          imm_pend, seen, ext_bit, ext_q;
  logic [TW-1:0] tick;
  logic [DW-1:0] code_r;

  logic ext_eff, int_on, tick_hit, ext_hit, adv, step_end, wr_ok, imm_wr;
  logic imm_go;
  logic [AW-1:0] imm_tgt;

  assign busy     = (st == S_RST);
  assign ext_eff  = ext_pin | ext_bit;
  assign int_on   = busy | ~ext_eff;
  assign tick_hit = int_on && (tick == TW'(TICK_DIV - 1));
  assign ext_hit  = ~busy & ext_eff & ext_clk & ~ext_q;
  assign adv      = tick_hit | ext_hit;
  assign step_end = adv && (ph == 2'd3);
  assign wr_ok    = wr_en & ~busy;
  assign imm_wr   = wr_ok & (wr_imm | imm_pin);
  assign imm_go   = imm_pend | imm_wr;
  assign imm_tgt  = imm_wr ? wr_addr : imm_ch;

  assign dac_code = code_r;
  assign chan     = ch;
  assign sample   = (st != S_HOLD) && (ph == 2'd3);

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] a);
    return (a == AW'(NCH - 1)) ? '0 : a + AW'(1);
  endfunction

  function automatic logic [DW-1:0] rd(input logic [AW-1:0] a);
    return (wr_ok && wr_addr == a) ? wr_data : mem[a];
  endfunction

  always_comb begin
    st_n  = st;
    ch_n  = ch;
    ptr_n = ptr;
    if (step_end) begin
      if (st == S_RST) begin
        st_n  = (ch == AW'(NCH - 1)) ? S_RUN : S_RST;
        ch_n  = nxt(ch);
        ptr_n = nxt(ch);
      end else if (sel_act) begin
        st_n = S_HOLD;
        ch_n = ptr;
      end else if (imm_go) begin
        st_n = S_IMM;
        ch_n = imm_tgt;
      end else if (st == S_RUN && !seen) begin
        ptr_n = nxt(ptr);
        ch_n  = nxt(ptr);
      end else begin
        st_n = S_RUN;
        ch_n = ptr;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (wr_ok)
      mem[wr_addr] <= wr_data;
    else if (busy && step_end)
      mem[ch] <= DEFAULT_CODE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_RST;
      ph       <= '0;
      ch       <= '0;
      ptr      <= '0;
      imm_ch   <= '0;
      imm_pend <= 1'b0;
      seen     <= 1'b0;
      ext_bit  <= 1'b0;
      ext_q    <= 1'b0;
      tick     <= '0;
      code_r   <= DEFAULT_CODE;
    end else begin
      st    <= st_n;
      ch    <= ch_n;
      ptr   <= ptr_n;
      ext_q <= ext_clk;
      if (adv) ph <= ph + 2'd1;
      tick <= (!int_on || tick_hit) ? '0 : tick + TW'(1);
      if (wr_ok) ext_bit <= wr_ext;
      seen <= (busy || step_end) ? 1'b0 : (seen | sel_act);
      if (step_end && st_n == S_IMM) begin
        imm_pend <= 1'b0;
      end else if (imm_wr) begin
        imm_pend <= 1'b1;
        imm_ch   <= wr_addr;
      end
      if (step_end)
        code_r <= (st_n == S_RST) ? DEFAULT_CODE : rd(ch_n);
    end
  end

endmodule

// File: rtl/sh_refresh_seq_chk.sv
module sh_refresh_seq_chk #(
  parameter int NCH = 32,
  parameter int DW = 16,
  parameter int TICK_DIV = 1250,
  parameter logic [DW-1:0] DEFAULT_CODE = 16'h4F2C,
  parameter int AW = 5,
  parameter int TW = 11
) (
  input logic          clk,
  input logic          rst_n,
  input logic          sel_act,
  input logic          wr_en,
  input logic          busy,
  input logic          sample,
  input logic [AW-1:0] chan,
  input logic [DW-1:0] dac_code,
  input logic [1:0]    st,
  input logic [AW-1:0] ptr,
  input logic [TW-1:0] tick,
  input logic          step_end,
  input logic          ext_eff,
  input logic          imm_pend
);
  localparam logic [1:0] RUN = 2'd1, HOLD = 2'd2, IMM = 2'd3;

  // R2
  tick_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick < TW'(TICK_DIV));

  // R3
  ext_tick_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_eff && !busy && $past(ext_eff) && !$past(busy)) |-> tick == '0);

  // R5
  hold_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == HOLD && sel_act && !busy) |=> st == HOLD);

  // R7
  imm_resume_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == IMM && step_end && !sel_act && !imm_pend && !wr_en) |=>
      (st == RUN && chan == $past(ptr)));

  // R8
  reset_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (chan == '0 && st == RUN));

  // R8
  reset_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && sample) |-> dac_code == DEFAULT_CODE);

  // R10
  code_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sample) |-> ($stable(dac_code) && $stable(chan)));
endmodule

bind sh_refresh_seq sh_refresh_seq_chk #(
  .NCH(NCH), .DW(DW), .TICK_DIV(TICK_DIV), .DEFAULT_CODE(DEFAULT_CODE),
  .AW(AW), .TW(TW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .sel_act(sel_act), .wr_en(wr_en), .busy(busy),
  .sample(sample), .chan(chan), .dac_code(dac_code), .st(st), .ptr(ptr),
  .tick(tick), .step_end(step_end), .ext_eff(ext_eff), .imm_pend(imm_pend)
);

// File: tb/tb_sh_refresh_seq.sv
module tb_sh_refresh_seq;
  localparam int NCH = 8;
  localparam int DW = 16;
  localparam int T = 3;
  localparam int AW = 3;
  localparam logic [15:0] DEF = 16'h4F2C;

  logic clk = 0, rst_n = 0;
  logic wr_en = 0, wr_imm = 0, wr_ext = 0, sel_act = 0, imm_pin = 0, ext_pin = 0, ext_clk = 0;
  logic [AW-1:0] wr_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic [DW-1:0] dac_code;
  logic [AW-1:0] chan;
  logic sample, busy;

  sh_refresh_seq #(.NCH(NCH), .DW(DW), .TICK_DIV(T), .DEFAULT_CODE(DEF)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .wr_imm(wr_imm), .wr_ext(wr_ext), .sel_act(sel_act), .imm_pin(imm_pin),
    .ext_pin(ext_pin), .ext_clk(ext_clk), .dac_code(dac_code), .chan(chan),
    .sample(sample), .busy(busy));

  always #4 clk = ~clk;

  int total = 0, bad = 0, cyc = 0, n = 0;
  int log_ch [1024];
  int log_code [1024];
  int log_t [1024];
  logic [15:0] mdl [NCH];
  logic sp_q = 0;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (sample && !sp_q && n < 1024) begin
      log_ch[n] = int'(chan);
      log_code[n] = int'(dac_code);
      log_t[n] = cyc;
      n = n + 1;
    end
    sp_q = sample;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic chk_seq(input int s, input int c, input int k, input string req);
    for (int j = 0; j < k; j++) begin
      int e = (c + j) % NCH;
      chk(log_ch[s+j] == e, req, log_ch[s+j], e);
      chk(log_code[s+j] == int'(mdl[e]), req, log_code[s+j], int'(mdl[e]));
    end
  endtask

  task automatic wr(input int a, input int d, input bit im, input bit ex);
    @(negedge clk);
    wr_en = 1; wr_addr = AW'(a); wr_data = DW'(d); wr_imm = im; wr_ext = ex;
    @(negedge clk);
    wr_en = 0; wr_imm = 0; wr_ext = 0;
  endtask

  task automatic ext_pulses(input int k);
    for (int i = 0; i < k; i++) begin
      @(negedge clk); ext_clk = 1;
      @(negedge clk);
      @(negedge clk); ext_clk = 0;
      @(negedge clk);
    end
  endtask

  task automatic wait_n(input int target);
    while (n < target) @(negedge clk);
  endtask

  task automatic count_busy(input string req);
    int cnt = 0;
    @(posedge clk);
    @(negedge clk);
    while (busy) begin cnt++; @(negedge clk); end
    chk(cnt == NCH*4*T - 1, req, cnt, NCH*4*T - 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int x, a, a2, n1, n2, tf;
    for (int i = 0; i < NCH; i++) mdl[i] = DEF;
    repeat (3) @(negedge clk);
    // R11 reset state
    chk(busy == 1, "R11 busy", busy, 1);
    chk(sample == 0, "R11 sample", sample, 0);
    chk(chan == 0, "R11 chan", chan, 0);
    chk(dac_code == DEF, "R11 code", dac_code, DEF);
    rst_n = 1;
    // R8 pass length and content
    count_busy("R8 pass length");
    chk(n == NCH, "R8 pass strobes", n, NCH);
    chk_seq(0, 0, NCH, "R8 default sweep");
    // R2 step spacing
    for (int i = 0; i + 1 < NCH; i++)
      chk(log_t[i+1] - log_t[i] == 4*T, "R2 spacing", log_t[i+1] - log_t[i], 4*T);
    // R1 rotation with wrap
    wait_n(3*NCH);
    chk_seq(NCH, 0, 2*NCH, "R1 rotation");

    // R5 / R6 burst
    @(negedge clk); sel_act = 1; x = int'(chan); n1 = n;
    wr((x+1)%NCH, 16'h1111, 0, 0); mdl[(x+1)%NCH] = 16'h1111;
    wr((x+3)%NCH, 16'h3333, 0, 0); mdl[(x+3)%NCH] = 16'h3333;
    wr((x+5)%NCH, 16'h5555, 0, 0); mdl[(x+5)%NCH] = 16'h5555;
    repeat (6*4*T) @(negedge clk);
    chk(n - n1 <= 1, "R5 suspended", n - n1, 1);
    n1 = n;
    sel_act = 0;
    wait_n(n1 + NCH + 1);
    chk_seq(n1, x, NCH + 1, "R6 resume order");

    // R7 immediate via word bit
    @(negedge clk); sel_act = 1; x = int'(chan); a = (x+3)%NCH;
    wr(a, 16'hA5A5, 1, 0); mdl[a] = 16'hA5A5;
    repeat (2*4*T) @(negedge clk);
    n1 = n; sel_act = 0; tf = cyc;
    wait_n(n1 + 3);
    chk(log_ch[n1] == a, "R7 target", log_ch[n1], a);
    chk(log_code[n1] == 16'hA5A5, "R7 code", log_code[n1], 16'hA5A5);
    chk(log_t[n1] - tf <= 8*T, "R7 latency", log_t[n1] - tf, 8*T);
    chk(log_ch[n1+1] == x, "R7 resume", log_ch[n1+1], x);
    chk(log_ch[n1+2] == (x+1)%NCH, "R7 continue", log_ch[n1+2], (x+1)%NCH);

    // R7 immediate via pin, latest write wins
    @(negedge clk); sel_act = 1; imm_pin = 1; x = int'(chan);
    a = (x+2)%NCH; a2 = (x+4)%NCH;
    wr(a, 16'h0202, 0, 0); mdl[a] = 16'h0202;
    wr(a2, 16'h0404, 0, 0); mdl[a2] = 16'h0404;
    repeat (2*4*T) @(negedge clk);
    n1 = n; sel_act = 0; imm_pin = 0;
    wait_n(n1 + 2);
    chk(log_ch[n1] == a2, "R7 latest", log_ch[n1], a2);
    chk(log_code[n1] == 16'h0404, "R7 latest code", log_code[n1], 16'h0404);
    chk(log_ch[n1+1] == x, "R7 pin resume", log_ch[n1+1], x);

    // R3 external pacing
    @(negedge clk); ext_pin = 1;
    repeat (2) @(negedge clk);
    n1 = n;
    ext_pulses(20);
    repeat (3) @(negedge clk);
    chk(n - n1 == 5, "R3 four edges per step", n - n1, 5);
    chk(log_t[n1+1] - log_t[n1] == 16, "R3 ext spacing", log_t[n1+1] - log_t[n1], 16);
    n2 = n;
    repeat (200) @(negedge clk);
    chk(n == n2, "R3 stall", n - n2, 0);

    // R4 pacing chosen by word bit
    ext_pin = 0;
    @(negedge clk); sel_act = 1;
    repeat (2*4*T) @(negedge clk);
    x = int'(chan);
    wr((x+1)%NCH, 16'h7777, 0, 1); mdl[(x+1)%NCH] = 16'h7777;
    sel_act = 0; n2 = n;
    repeat (100) @(negedge clk);
    chk(n == n2, "R4 bit selects ext", n - n2, 0);
    ext_pulses(8);
    chk(n > n2, "R4 ext edges advance", n - n2, 1);
    @(negedge clk); sel_act = 1;
    wr((x+2)%NCH, 16'h8888, 0, 0); mdl[(x+2)%NCH] = 16'h8888;
    sel_act = 0; n2 = n;
    repeat (100) @(negedge clk);
    chk(n > n2, "R4 back to internal", n - n2, 1);

    // R8 / R9 second pass: ext pin set, select held, write attempt
    @(negedge clk); ext_pin = 1; sel_act = 1; rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1; n1 = n;
    for (int i = 0; i < NCH; i++) mdl[i] = DEF;
    fork
      count_busy("R8 internal pacing in pass");
      begin
        repeat (10) @(negedge clk);
        wr_en = 1; wr_addr = 3; wr_data = 16'h1234; wr_imm = 1;
        @(negedge clk);
        wr_en = 0; wr_imm = 0;
      end
    join
    chk_seq(n1, 0, NCH, "R8 uninterrupted sweep");
    ext_pin = 0;
    repeat (2*4*T) @(negedge clk);
    sel_act = 0;
    wait_n(n1 + 2*NCH + 1);
    chk(log_ch[n1+NCH] == 0, "R8 first channel", log_ch[n1+NCH], 0);
    chk_seq(n1 + NCH + 1, 0, NCH, "R9 blocked write");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule